// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits in front of a byte-writable memory array and decides, for every completed write strobe, whether the write may reach the array. It watches the address and data of each strobe and recognises two fixed command sequences. The three-step arm sequence turns protection on and opens one page-load window. The six-step disable sequence turns protection off. A protection flag holds the mode. It is not cleared by the block reset and models a nonvolatile cell. A separate preload input sets its value at power-up.

With protection off, any write that is not a command step is passed to the array. With protection on and no window open, a write that is not a command step is discarded and flagged for one cycle. Command-step writes are never passed and never flagged. A window accepts writes until it has taken PAGE_BYTES of them, or until GAP_CYC clock cycles pass with no strobe. It then closes, and the block is protected again.

The controller has seven states. ST_IDLE waits for a first step. ST_K1 has seen the first unlock step. ST_K2 has seen the second unlock step. ST_OFF3, ST_OFF4 and ST_OFF5 have seen the third, fourth and fifth steps of the disable sequence. ST_WIN is the open window. The transitions are:
- *start*: ST_IDLE to ST_K1.
- *unlock2*: ST_K1 to ST_K2.
- *arm*: ST_K2 to ST_WIN.
- *off3*: ST_K2 to ST_OFF3.
- *off4*: ST_OFF3 to ST_OFF4.
- *off5*: ST_OFF4 to ST_OFF5.
- *clear*: ST_OFF5 to ST_IDLE.
- *restart*: any matching state to ST_K1 or ST_IDLE on a mismatching write.
- *close*: ST_WIN to ST_IDLE.
- *reset*: any state to ST_IDLE.

Top module: `wp_seq_guard`

## Requirements
- R1: With prot_on low, a strobe that is not a command step gives wr_allow high for exactly the cycle after the strobe.
- R2: With prot_on high and win_open low, a strobe that is not a command step gives wr_reject high for the cycle after the strobe, and wr_allow stays low.
- R3: The three strobes data 0xAA at address 0x5555, data 0x55 at 0x2AAA and data 0xA0 at 0x5555 set prot_on and win_open in the cycle after the third strobe. This holds whether prot_on was high or low before.
- R4: Every strobe while win_open is high gives wr_allow. The window closes after the PAGE_BYTES-th such strobe, so win_open is low in the cycle after it.
- R5: When GAP_CYC consecutive cycles pass without a strobe while the window is open, win_open falls in the cycle after the last of them. With GAP_CYC-1 idle cycles it stays high.
- R6: The six strobes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x20@0x5555 clear prot_on in the cycle after the sixth. After that, ordinary writes are allowed.
- R7: A strobe that is accepted as a step of either command sequence raises neither wr_allow nor wr_reject.
- R8: A strobe that does not match the expected next step abandons the sequence and is judged again as a possible first step. If it is 0xAA@0x5555 it starts a new sequence. Otherwise it is allowed or rejected as R1/R2 say.
- R9: rst_n returns the controller to ST_IDLE, closes the window and clears both pulse outputs. It leaves prot_on unchanged.
- R10: When prot_load is high at a clock edge, prot_on takes the value of prot_load_val in the next cycle. This overrides any command sequence completing in the same cycle.
- R11: wr_allow and wr_reject are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequence state (not of prot_on) |
| prot_load | input | 1 | Preload strobe for the persistent protection flag |
| prot_load_val | input | 1 | Value loaded into the protection flag |
| wr_stb | input | 1 | One-cycle pulse marking a completed write |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | 8 | Data of the write |
| wr_allow | output | 1 | Write goes to the array (cycle after the strobe) |
| wr_reject | output | 1 | Write discarded by protection (cycle after the strobe) |
| prot_on | output | 1 | Protection flag |
| win_open | output | 1 | A page-load window is open |

## Verification
The bench targets the edges where a subtly wrong matcher goes astray.

| Corner case | What a wrong design does |
|---|---|
| A repeated first step inside a sequence | A matcher that does not re-evaluate the breaking write rejects it instead of restarting. |
| A near-complete disable sequence broken at its sixth step | A design that matches only the data and not the address drops protection anyway. |
| Exactly PAGE_BYTES window writes, then one more | An off-by-one byte counter either lets the extra write through or cuts the last legal one. |
| GAP_CYC-1 and GAP_CYC idle cycles | A wrong gap counter shuts the window early or keeps it open too long. |
| A reset while the window is open | A reset that clears the flag loses protection. |

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_KEY1 = 8'hAA;
    localparam logic [CODE_W-1:0] CODE_KEY2 = 8'h55;
    localparam logic [CODE_W-1:0] CODE_ARM  = 8'hA0;
    localparam logic [CODE_W-1:0] CODE_OFF  = 8'h80;
    localparam logic [CODE_W-1:0] CODE_CLR  = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_OFF3,
        ST_OFF4,
        ST_OFF5,
        ST_WIN
    } wp_state_e;

    typedef struct packed {
        logic key1;
        logic key2;
        logic arm;
        logic off;
        logic clr;
    } wp_match_t;
endpackage

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
    import wp_pkg::*;
#(
    parameter int               ADDR_W     = 15,
    parameter logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555,
    parameter logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] data,
    output wp_match_t         hit
);
    logic at_a;
    logic at_b;

    always_comb begin
        at_a     = (addr == KEY_ADDR_A);
        at_b     = (addr == KEY_ADDR_B);
        hit.key1 = at_a && (data == CODE_KEY1);
        hit.key2 = at_b && (data == CODE_KEY2);
        hit.arm  = at_a && (data == CODE_ARM);
        hit.off  = at_a && (data == CODE_OFF);
        hit.clr  = at_a && (data == CODE_CLR);
    end
endmodule

// File: rtl/wp_page_window.sv
module wp_page_window #(
    parameter int PAGE_BYTES = 128,
    parameter int GAP_CYC    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open,
    input  logic stb,
    output logic close_evt
);
    localparam int BW = $clog2(PAGE_BYTES + 1);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam logic [BW-1:0] LAST_BYTE = BW'(PAGE_BYTES - 1);
    localparam logic [GW-1:0] LAST_GAP  = GW'(GAP_CYC - 1);

    logic [BW-1:0] byte_cnt;
    logic [GW-1:0] gap_cnt;

    always_comb begin
        close_evt = open && ((stb && (byte_cnt == LAST_BYTE)) ||
                             (!stb && (gap_cnt == LAST_GAP)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            gap_cnt  <= '0;
        end else if (!open || close_evt) begin
            byte_cnt <= '0;
            gap_cnt  <= '0;
        end else if (stb) begin
            byte_cnt <= byte_cnt + 1'b1;
            gap_cnt  <= '0;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R4
    byte_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt < BW'(PAGE_BYTES));
    // R5
    gap_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt < GW'(GAP_CYC));
    // R4
    closed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> (byte_cnt == '0 && gap_cnt == '0));
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
    import wp_pkg::*;
#(
    parameter int               ADDR_W     = 15,
    parameter logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555,
    parameter logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA,
    parameter int               PAGE_BYTES = 128,
    parameter int               GAP_CYC    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_load,
    input  logic              prot_load_val,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wr_allow,
    output logic              wr_reject,
    output logic              prot_on,
    output logic              win_open
);
    wp_state_e state, nxt;
    wp_match_t hit;
    logic      close_evt;
    logic      allow_n, reject_n, prot_set, prot_clr;
    logic      fresh_allow, fresh_reject;
    wp_state_e fresh_nxt;

    wp_cmd_match #(
        .ADDR_W    (ADDR_W),
        .KEY_ADDR_A(KEY_ADDR_A),
        .KEY_ADDR_B(KEY_ADDR_B)
    ) match_i (
        .addr(wr_addr),
        .data(wr_data),
        .hit (hit)
    );

    wp_page_window #(
        .PAGE_BYTES(PAGE_BYTES),
        .GAP_CYC   (GAP_CYC)
    ) window_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (state == ST_WIN),
        .stb      (wr_stb),
        .close_evt(close_evt)
    );

    // judgement of a write that does not continue a sequence
    always_comb begin
        fresh_nxt    = hit.key1 ? ST_K1 : ST_IDLE;
        fresh_allow  = !hit.key1 && !prot_on;
        fresh_reject = !hit.key1 && prot_on;
    end

    always_comb begin
        nxt      = state;
        allow_n  = 1'b0;
        reject_n = 1'b0;
        prot_set = 1'b0;
        prot_clr = 1'b0;
        unique case (state)
            ST_IDLE: if (wr_stb) begin
                nxt = fresh_nxt; allow_n = fresh_allow; reject_n = fresh_reject;
            end
            ST_K1: if (wr_stb) begin
                if (hit.key2) nxt = ST_K2;
                else begin
                    nxt = fresh_nxt; allow_n = fresh_allow; reject_n = fresh_reject;
                end
            end
            ST_K2: if (wr_stb) begin
                if (hit.arm) begin
                    nxt = ST_WIN; prot_set = 1'b1;
                end else if (hit.off) nxt = ST_OFF3;
                else begin
                    nxt = fresh_nxt; allow_n = fresh_allow; reject_n = fresh_reject;
                end
            end
            ST_OFF3: if (wr_stb) begin
                if (hit.key1) nxt = ST_OFF4;
                else begin
                    nxt = fresh_nxt; allow_n = fresh_allow; reject_n = fresh_reject;
                end
            end
            ST_OFF4: if (wr_stb) begin
                if (hit.key2) nxt = ST_OFF5;
                else begin
                    nxt = fresh_nxt; allow_n = fresh_allow; reject_n = fresh_reject;
                end
            end
            ST_OFF5: if (wr_stb) begin
                if (hit.clr) begin
                    nxt = ST_IDLE; prot_clr = 1'b1;
                end else begin
                    nxt = fresh_nxt; allow_n = fresh_allow; reject_n = fresh_reject;
                end
            end
            ST_WIN: begin
                allow_n = wr_stb;
                if (close_evt) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // sequence state and pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wr_allow  <= 1'b0;
            wr_reject <= 1'b0;
        end else begin
            state     <= nxt;
            wr_allow  <= allow_n;
            wr_reject <= reject_n;
        end
    end

    // persistent protection flag: deliberately outside rst_n
    always_ff @(posedge clk) begin
        if (prot_load)     prot_on <= prot_load_val;
        else if (prot_set) prot_on <= 1'b1;
        else if (prot_clr) prot_on <= 1'b0;
    end

    always_comb win_open = (state == ST_WIN);

    // R11
    allow_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_allow && wr_reject));
    // R1
    allow_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |-> $past(wr_stb));
    // R2
    reject_needs_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(prot_on) && !$past(win_open));
    // R6
    prot_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> ($past(prot_load) || $past(state == ST_OFF5)));
    // R3
    win_needs_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> (prot_on || $past(prot_load)));
    // R7
    cmd_step_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && state == ST_K1 && hit.key2) |=> (!wr_allow && !wr_reject));
endmodule

// File: tb/wp_seq_guard_tb.sv
module wp_seq_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 15;
    localparam int PAGE_BYTES = 128;
    localparam int GAP_CYC    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prot_load = 1'b1;
    logic              prot_load_val = 1'b0;
    logic              wr_stb = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              wr_allow, wr_reject, prot_on, win_open;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // behavioural reference model
    int m_state = 0;   // 0 idle,1..2 unlock steps,3..5 disable steps,6 window
    bit m_prot = 0, m_allow = 0, m_reject = 0;
    int m_bytes = 0, m_idle = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_seq_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .GAP_CYC(GAP_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .prot_load(prot_load), .prot_load_val(prot_load_val),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_allow(wr_allow), .wr_reject(wr_reject), .prot_on(prot_on), .win_open(win_open));

    function automatic int step_code(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        if (a == 15'h5555 && d == 8'hAA) return 1;
        if (a == 15'h2AAA && d == 8'h55) return 2;
        if (a == 15'h5555 && d == 8'hA0) return 3;
        if (a == 15'h5555 && d == 8'h80) return 4;
        if (a == 15'h5555 && d == 8'h20) return 5;
        return 0;
    endfunction

    always @(posedge clk) begin
        int c;
        bit p_old;
        bit set_p, clr_p;
        p_old = m_prot; set_p = 0; clr_p = 0;
        c = step_code(wr_addr, wr_data);
        if (!rst_n) begin
            m_state = 0; m_allow = 0; m_reject = 0; m_bytes = 0; m_idle = 0;
        end else begin
            m_allow = 0; m_reject = 0;
            if (m_state == 6) begin
                if (wr_stb) begin
                    m_allow = 1; m_bytes++; m_idle = 0;
                    if (m_bytes == PAGE_BYTES) m_state = 0;
                end else begin
                    m_idle++;
                    if (m_idle == GAP_CYC) m_state = 0;
                end
            end else if (wr_stb) begin
                bit adv;
                adv = 0;
                case (m_state)
                    1: if (c == 2) begin m_state = 2; adv = 1; end
                    2: if (c == 3) begin m_state = 6; adv = 1; set_p = 1; m_bytes = 0; m_idle = 0; end
                       else if (c == 4) begin m_state = 3; adv = 1; end
                    3: if (c == 1) begin m_state = 4; adv = 1; end
                    4: if (c == 2) begin m_state = 5; adv = 1; end
                    5: if (c == 5) begin m_state = 0; adv = 1; clr_p = 1; end
                    default: adv = 0;
                endcase
                if (!adv) begin
                    if (c == 1) m_state = 1;
                    else begin
                        m_state = 0;
                        if (p_old) m_reject = 1; else m_allow = 1;
                    end
                end
            end
        end
        if (prot_load) m_prot = prot_load_val;
        else if (set_p) m_prot = 1;
        else if (clr_p) m_prot = 0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R11 every-cycle comparison against the model
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check(wr_allow == m_allow, "R1 model allow", wr_allow, m_allow);
        check(wr_reject == m_reject, "R2 model reject", wr_reject, m_reject);
        check(prot_on == m_prot, "R9 model prot", prot_on, m_prot);
        check(win_open == (m_state == 6), "R4 model window", win_open, m_state == 6);
        check(!(wr_allow && wr_reject), "R11 exclusive", wr_allow + wr_reject, 1);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic arm();
        wr(15'h5555, 8'hAA);
        wr(15'h2AAA, 8'h55);
        wr(15'h5555, 8'hA0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        prot_load = 1'b0;
        rst_n = 1'b1;
        tick();
        check(prot_on == 0 && wr_allow == 0 && win_open == 0, "R9 reset state", prot_on, 0);

        wr(15'h0100, 8'h12);
        check(wr_allow == 1, "R1 unprotected write", wr_allow, 1);
        tick();
        check(wr_allow == 0, "R1 single pulse", wr_allow, 0);

        wr(15'h5555, 8'hAA);
        check(!wr_allow && !wr_reject, "R7 step silent", wr_allow, 0);
        wr(15'h0200, 8'h34);
        check(wr_allow == 1, "R8 broken seq write allowed", wr_allow, 1);

        arm();
        check(prot_on == 1 && win_open == 1, "R3 arm from unprotected", prot_on, 1);
        check(!wr_allow && !wr_reject, "R7 arm step silent", wr_allow, 0);
        wr(15'h0300, 8'h01); wr(15'h0301, 8'h02); wr(15'h0302, 8'h03);
        check(wr_allow == 1, "R4 window write", wr_allow, 1);
        idle(GAP_CYC - 1);
        check(win_open == 1, "R5 gap minus one keeps window", win_open, 1);
        idle(1);
        check(win_open == 0, "R5 gap closes window", win_open, 0);

        wr(15'h0300, 8'h55);
        check(wr_reject == 1 && wr_allow == 0, "R2 protected reject", wr_reject, 1);

        wr(15'h5555, 8'hAA);
        wr(15'h5555, 8'hAA);
        check(!wr_reject && !wr_allow, "R8 repeated first step restarts", wr_reject, 0);
        wr(15'h2AAA, 8'h55);
        wr(15'h5555, 8'hA0);
        check(win_open == 1, "R3 arm when protected", win_open, 1);
        for (int i = 0; i < PAGE_BYTES; i++) wr(ADDR_W'(15'h0400 + i), 8'(i));
        check(wr_allow == 1 && win_open == 0, "R4 full page closes", win_open, 0);
        wr(15'h0400, 8'hEE);
        check(wr_reject == 1, "R4 write past page rejected", wr_reject, 1);

        wr(15'h5555, 8'hAA);
        wr(15'h5555, 8'h11);
        check(wr_reject == 1, "R8 mismatch rejected", wr_reject, 1);

        arm();
        wr(15'h0500, 8'h77);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        check(prot_on == 1 && win_open == 0, "R9 reset keeps prot", prot_on, 1);
        wr(15'h0501, 8'h78);
        check(wr_reject == 1, "R9 after reset rejected", wr_reject, 1);

        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
        wr(15'h5555, 8'hAA);
        check(prot_on == 1 && !wr_reject, "R8 broken disable keeps prot", prot_on, 1);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
        wr(15'h2AAA, 8'h20);
        check(prot_on == 1 && wr_reject == 1, "R6 wrong address final step", prot_on, 1);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
        wr(15'h5555, 8'h20);
        check(prot_on == 0 && !wr_allow && !wr_reject, "R6 disable clears prot", prot_on, 0);
        wr(15'h0600, 8'h99);
        check(wr_allow == 1, "R6 write allowed after disable", wr_allow, 1);

        prot_load = 1'b1; prot_load_val = 1'b1;
        tick();
        prot_load = 1'b0;
        check(prot_on == 1, "R10 preload sets prot", prot_on, 1);
        wr(15'h0601, 8'h9A);
        check(wr_reject == 1, "R10 preload enforced", wr_reject, 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule